// File: doc/BRIEF.md
# Bit-Select Prescaled PWM Timer

This block produces one pulse-width-modulated output from a free-running 8-bit counter. The counter steps on a slow tick enable of about 32 kHz. There is no period register. Instead, a 2-bit prescaler picks the counter bit that forces the counter back to zero. The choice gives a period of 128, 64, 32 or 16 ticks, which is roughly 250 Hz, 500 Hz, 1 kHz or 2 kHz. The faster settings leave fewer low counter bits for the duty comparison.

Software uses a byte-wide register port with two locations:

- A control byte holds the enable flag and the prescaler.
- A duty byte holds a 7-bit high-time count.

Both take effect as soon as they are written. There is no shadow copy, and the counter is not cleared. A new duty value can therefore change the waveform in the middle of a period. A shorter prescaler setting can also cut the current period short.

Top module: `bitsel_pwm`

## Requirements
- R1: After a synchronous active-high reset, enable, prescaler, duty and counter are all zero. Both register reads return 0x00 and the output is low.
- R2: Address 0 is the control byte, with enable in bit 7 and the prescaler in bits [1:0]. Bits [6:2] read as zero. Address 1 is the duty byte, with the duty in bits [6:0] and bit 7 reading as zero. Writes happen on a clock edge with the write strobe high. Read data is combinational from the address.
- R3: While enabled, the counter advances by one on each clock edge with the tick high. Otherwise it holds, and so does the output.
- R4: With prescaler p, the period is 2^(7−p) ticks. The counter runs from 0 to 2^(7−p)−1 and then returns to 0.
- R5: The output is high while the counter value modulo 2^(7−p) is strictly below the duty value, and low otherwise. A duty of 0 keeps the output low.
- R6: A duty of 2^(7−p) or more keeps the output high for the whole period. At prescaler 0 the largest storable duty, 127, leaves exactly one low tick in every 128.
- R7: A new duty value changes the output from the clock edge that writes it. The counter is not cleared.
- R8: A prescaler change does not clear the counter. If the counter plus one is at or above the new period, the next tick returns it to 0.
- R9: While enable is 0, the counter is held at zero and the output is low. Setting enable starts the count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable pulse, about 32 kHz |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 is control, 1 is duty |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for the selected address |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures the period at all four prescaler settings from the spacing of single-tick pulses. A wrong reset-bit choice would show up as a doubled or halved period.

It checks that a duty at or above the period pins the output high. It also checks that duty 127 at prescaler 0 leaves exactly one low tick. A comparison over too many counter bits would break both checks.

It switches the prescaler from 0 to 3 with the counter at 100. The output must stay at the unchanged count until the next tick and then return to zero. A design that clears on the switch, or wraps by modulo, would show a different phase.

Mid-period duty writes, disable and re-enable, and the read-back of the reserved bits are covered as well. These run alongside a long stretch of random writes and ticks that is checked against a cycle model.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  // Period in ticks for a given counter width and prescaler value.
  function automatic int period_ticks(int cnt_w, int ps);
    return 1 << (cnt_w - 1 - ps);
  endfunction

  // Mask of the counter bits that take part in the duty compare.
  function automatic int low_mask(int cnt_w, int ps);
    return period_ticks(cnt_w, ps) - 1;
  endfunction
endpackage

// File: rtl/bsp_regs.sv
module bsp_regs #(
  parameter int DATA_W = 8,
  parameter int PS_W   = 2,
  localparam int DUTY_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              en,
  output logic [PS_W-1:0]   ps,
  output logic [DUTY_W-1:0] duty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      ps   <= '0;
      duty <= '0;
    end else if (wr_en) begin
      if (addr) begin
        duty <= wdata[DUTY_W-1:0];
      end else begin
        en <= wdata[DATA_W-1];
        ps <= wdata[PS_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr) begin
      rdata[DUTY_W-1:0] = duty;
    end else begin
      rdata[DATA_W-1] = en;
      rdata[PS_W-1:0] = ps;
    end
  end
endmodule

// File: rtl/bsp_counter.sv
module bsp_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] nxt;

  always_comb begin
    nxt  = cnt + CNT_W'(1);
    // At or past the selected reset bit: this also catches a counter
    // left beyond a freshly shortened period.
    wrap = (nxt >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= wrap ? '0 : nxt;
    end
  end
endmodule

// File: rtl/bsp_compare.sv
module bsp_compare #(
  parameter int CNT_W = 8,
  localparam int DUTY_W = CNT_W - 1
) (
  input  logic              en,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  lim,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm
);
  logic [CNT_W-1:0] low_bits;

  always_comb begin
    low_bits = cnt & (lim - CNT_W'(1));
    pwm      = en && (low_bits < CNT_W'(duty));
  end
endmodule

// File: rtl/bitsel_pwm.sv
module bitsel_pwm #(
  parameter int CNT_W = 8,
  parameter int PS_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             pwm_out
);
  localparam int DUTY_W = CNT_W - 1;

  logic              en;
  logic [PS_W-1:0]   ps;
  logic [DUTY_W-1:0] duty;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  lim;
  logic              wrap;

  assign lim = CNT_W'(bsp_pkg::period_ticks(CNT_W, int'(ps)));

  bsp_regs #(.DATA_W(CNT_W), .PS_W(PS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .en(en), .ps(ps), .duty(duty)
  );

  bsp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .lim(lim),
    .cnt(cnt), .wrap(wrap)
  );

  bsp_compare #(.CNT_W(CNT_W)) u_cmp (
    .en(en), .cnt(cnt), .lim(lim), .duty(duty), .pwm(pwm_out)
  );
endmodule

// File: rtl/bsp_checker.sv
module bsp_checker #(
  parameter int CNT_W = 8,
  parameter int PS_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             addr,
  input logic [CNT_W-1:0] rdata,
  input logic             en,
  input logic [PS_W-1:0]  ps,
  input logic [CNT_W-2:0] duty,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim,
  input logic             wrap,
  input logic             pwm_out
);
  a_r2_rsvd_ctrl: assert property (@(posedge clk) disable iff (rst)
    !addr |-> rdata[CNT_W-2:PS_W] == '0);

  a_r2_rsvd_duty: assert property (@(posedge clk) disable iff (rst)
    addr |-> !rdata[CNT_W-1]);

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    en && tick && !wrap |=> cnt == $past(cnt) + CNT_W'(1));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    en && !tick |=> $stable(cnt));

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    en && tick && (cnt == lim - CNT_W'(1)) |=> cnt == '0);

  a_r4_top_bit_clear: assert property (@(posedge clk) disable iff (rst)
    !cnt[CNT_W-1]);

  a_r5_duty_zero_low: assert property (@(posedge clk) disable iff (rst)
    duty == '0 |-> !pwm_out);

  a_r6_full_high: assert property (@(posedge clk) disable iff (rst)
    en && (CNT_W'(duty) >= lim) |-> pwm_out);

  a_r9_held_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0);

  a_r9_off_low: assert property (@(posedge clk) disable iff (rst)
    !en |-> !pwm_out);

  a_r9_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |-> cnt == '0);
endmodule

bind bitsel_pwm bsp_checker #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .addr(addr), .rdata(rdata),
  .en(en), .ps(ps), .duty(duty), .cnt(cnt), .lim(lim), .wrap(wrap),
  .pwm_out(pwm_out)
);

// File: tb/sim_bitsel_pwm.sv
`timescale 1ns/1ps
module sim_bitsel_pwm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pwm_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model of the registers and the counter
  int m_en = 0, m_ps = 0, m_duty = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  bitsel_pwm u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  function automatic int period_of(int ps);
    return 128 >> ps;
  endfunction

  function automatic int exp_out();
    if (m_en == 0) return 0;
    return ((m_cnt % period_of(m_ps)) < m_duty) ? 1 : 0;
  endfunction

  function automatic int exp_read(int a);
    if (a != 0) return m_duty;
    return m_en * 128 + m_ps;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: apply inputs, update the model after the edge, check at negedge.
  task automatic cyc(input bit t, input bit w, input bit a, input int d);
    tick = t; wr_en = w; addr = a; wdata = d[7:0];
    @(posedge clk);
    if (rst) begin
      m_en = 0; m_ps = 0; m_duty = 0; m_cnt = 0;
    end else begin
      if (m_en == 0) m_cnt = 0;
      else if (t) m_cnt = (m_cnt + 1 >= period_of(m_ps)) ? 0 : m_cnt + 1;
      if (w) begin
        if (a) m_duty = d % 128;
        else begin m_en = (d / 128) % 2; m_ps = d % 4; end
      end
    end
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R5 output vs model", int'(pwm_out), exp_out());
  endtask

  task automatic rd(input bit a, string tag);
    addr = a;
    #0.5;
    chk(tag, int'(rdata), exp_read(a));
  endtask

  task automatic set_ctrl(int en, int ps);
    cyc(1'b0, 1'b1, 1'b0, en * 128 + ps);
  endtask

  task automatic set_duty(int d);
    cyc(1'b0, 1'b1, 1'b1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    cyc(1'b0, 1'b0, 1'b0, 0);
    cyc(1'b0, 1'b0, 1'b0, 0);
    rst = 1'b0;
    // R1 reset state
    rd(1'b0, "R1 ctrl after reset");
    rd(1'b1, "R1 duty after reset");
    chk("R1 output after reset", int'(pwm_out), 0);

    // R2 read back, reserved bits zero
    set_ctrl(0, 3);
    cyc(1'b0, 1'b1, 1'b0, 8'hFF);
    addr = 1'b0; #0.5; chk("R2 ctrl readback 0xFF", int'(rdata), 8'h83);
    cyc(1'b0, 1'b1, 1'b1, 8'hFF);
    addr = 1'b1; #0.5; chk("R2 duty readback 0xFF", int'(rdata), 8'h7F);
    set_ctrl(0, 0);

    // R4 period per prescaler, measured from single-tick pulses
    for (int p = 0; p < 4; p++) begin
      int first, second, idx;
      set_ctrl(0, 0);
      set_duty(1);
      set_ctrl(1, p);
      first = -1; second = -1; idx = 0;
      for (int k = 0; k < 300; k++) begin
        cyc(1'b1, 1'b0, 1'b0, 0);
        idx++;
        if (pwm_out) begin
          if (first < 0) first = idx;
          else if (second < 0) second = idx;
        end
      end
      chk($sformatf("R4 period ps=%0d", p), second - first, period_of(p));
    end

    // R3 hold without tick
    set_ctrl(0, 0);
    set_duty(5);
    set_ctrl(1, 0);
    repeat (4) cyc(1'b1, 1'b0, 1'b0, 0);
    begin
      int held = 1;
      repeat (20) begin
        cyc(1'b0, 1'b0, 1'b0, 0);
        if (pwm_out != 1'b1) held = 0;
      end
      chk("R3 output holds without tick", held, 1);
    end
    cyc(1'b1, 1'b0, 1'b0, 0);
    chk("R3 fifth tick reaches duty", int'(pwm_out), 0);

    // R6 full duty at ps=3, and 127/128 at ps=0
    set_ctrl(1, 3);
    set_duty(16);
    begin
      int lows = 0;
      repeat (40) begin cyc(1'b1, 1'b0, 1'b0, 0); if (!pwm_out) lows++; end
      chk("R6 duty>=period stays high", lows, 0);
    end
    set_ctrl(0, 0);
    set_duty(127);
    set_ctrl(1, 0);
    begin
      int lows = 0;
      repeat (128) begin cyc(1'b1, 1'b0, 1'b0, 0); if (!pwm_out) lows++; end
      chk("R6 duty 127 at ps0 low ticks", lows, 1);
    end

    // R7 duty change mid-period
    set_ctrl(0, 0);
    set_duty(10);
    set_ctrl(1, 0);
    repeat (20) cyc(1'b1, 1'b0, 1'b0, 0);
    chk("R7 before change", int'(pwm_out), 0);
    set_duty(30);
    chk("R7 raise duty immediate", int'(pwm_out), 1);
    set_duty(21);
    chk("R7 counter kept (20<21)", int'(pwm_out), 1);
    set_duty(20);
    chk("R7 counter kept (20<20 false)", int'(pwm_out), 0);

    // R8 prescaler switch with counter past new period
    set_ctrl(0, 0);
    set_duty(1);
    set_ctrl(1, 0);
    repeat (100) cyc(1'b1, 1'b0, 1'b0, 0);
    set_ctrl(1, 3);
    chk("R8 no clear on switch (100 mod 16 = 4)", int'(pwm_out), 0);
    cyc(1'b1, 1'b0, 1'b0, 0);
    chk("R8 clears on next tick", int'(pwm_out), 1);
    cyc(1'b1, 1'b0, 1'b0, 0);
    chk("R8 continues from zero", int'(pwm_out), 0);

    // R9 disable and re-enable
    set_duty(100);
    set_ctrl(0, 3);
    chk("R9 disabled output low", int'(pwm_out), 0);
    repeat (5) cyc(1'b1, 1'b0, 1'b0, 0);
    set_duty(1);
    set_ctrl(1, 2);
    chk("R9 restart from zero", int'(pwm_out), 1);
    cyc(1'b1, 1'b0, 1'b0, 0);
    chk("R9 second count", int'(pwm_out), 0);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit t, w, a;
      int d;
      t = ($urandom % 2) == 1;
      w = ($urandom % 16) == 0;
      a = ($urandom % 2) == 1;
      d = int'($urandom % 256);
      if (w && !a && ($urandom % 4) != 0) d = d | 128;
      cyc(t, w, a, d);
      if ((k % 7) == 0) rd(($urandom % 2) == 1, "R2 random readback");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule